// File: doc/BRIEF.md
# Three-Wire Serial Register Read Port

This block is the target side of a three-wire register bus. The three wires are an active-low select, a serial clock driven by the host, and one shared data line. The block sits on a fast system clock. It brings the serial clock, the select and the incoming data into that clock domain through synchronisers, and it detects serial clock edges there. The shared data line is split into a data input, a data output and an output enable, and the pad ring joins them.

Each frame begins with a header: four address bits, most significant first, then a direction bit. When the direction bit calls for a read, the block turns the line around on the next falling serial clock edge and shifts out the selected register, most significant bit first. Each register's width, from 1 to 32 bits, and whether its address is populated come from a parameter table. Register contents arrive on a flat parallel input.

Reads that run past the end of a register return defined values. An unpopulated address also returns defined values. The host may end a frame at any bit by releasing select.

Top module: `ser_reg_rd_slave`

## Requirements
- R1: A frame header is four address bits, most significant first, then a direction bit, each sampled on a rising serial clock edge while select is low. Direction 0 selects a read.
- R2: The output enable stays low through the whole header. It also stays low between the fifth rising edge and the next falling edge, and it goes high in response to that falling edge.
- R3: Read data leaves the block most significant bit first. Each bit is updated in response to a falling serial clock edge and holds until the next falling edge.
- R4: On a populated address, every data bit after the last bit of the register is 0.
- R5: On an unpopulated address, the first 32 data bits are 1 and every later data bit is 0.
- R6: When select goes high, the output enable falls within six system clocks and all frame state is cleared. A frame cut short after any number of bits, including two, leaves the next frame unaffected.
- R7: When the direction bit is 1, the output enable stays low for the rest of the frame.
- R8: The register value is captured when the header completes. Changes on the parallel input later in the same frame do not alter the bits shifted out.
- R9: During and after reset, the output enable and the data output are 0.
- R10: Each address uses its own width from the parameter table (field `a` at bits `[6a+5:6a]`) and its own valid flag (bit `a` of the mask). Widths of 1 and 32 are both handled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_ni | input | 1 | Bus select, active low |
| sclk_i | input | 1 | Serial clock from host |
| sdata_i | input | 1 | Data line, input side |
| sdata_o | output | 1 | Data line, output side |
| sdata_oe_o | output | 1 | Data line drive enable |
| regs_i | input | 16*32 | Register contents, address a at bits [32a+31:32a] |

## Verification
Every one of the 16 addresses is read twice, with two complementary data patterns, so a stuck or swapped data bit shows in one pass or the other. Each read runs three bits beyond the register width, which exposes any difference between the last real bit and the zero fill. Unpopulated addresses are clocked for 36 data bits, which separates the 32-bit run of ones from the trailing zeros. Further frames cover a two-bit read followed by a fresh read, a frame with direction 1, and a parallel input that changes mid-read, which tell a correct abort, write ignore and snapshot apart from a design that leaks state between frames or samples the register late.

// File: rtl/ser_rd_pkg.sv
package ser_rd_pkg;
  typedef enum logic [1:0] {
    ST_HDR  = 2'd0,
    ST_READ = 2'd1,
    ST_SKIP = 2'd2
  } frame_st_e;
endpackage

// File: rtl/ser_in_sync.sv
module ser_in_sync #(
  parameter int          N       = 3,
  parameter int          STAGES  = 2,
  parameter int          CLK_BIT = 0,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] level_o,
  output logic         clk_rise_o,
  output logic         clk_fall_o
);
  logic [N-1:0] stage_q [STAGES];
  logic         clk_prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      stage_q[s] <= RST_VAL;
      else if (s == 0)  stage_q[s] <= async_i;
      else              stage_q[s] <= stage_q[(s > 0) ? s-1 : 0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clk_prev_q <= RST_VAL[CLK_BIT];
    else         clk_prev_q <= stage_q[STAGES-1][CLK_BIT];
  end

  assign level_o    = stage_q[STAGES-1];
  assign clk_rise_o = level_o[CLK_BIT] & ~clk_prev_q;
  assign clk_fall_o = ~level_o[CLK_BIT] & clk_prev_q;
endmodule

// File: rtl/ser_frame_ctrl.sv
module ser_frame_ctrl
  import ser_rd_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int ONES_LEN = 32,
  localparam int CNT_W   = $clog2(ONES_LEN + 1),
  localparam int HC_W    = $clog2(ADDR_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              din_i,
  output frame_st_e         state_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  idx_o,
  output logic              load_o,
  output logic              shift_o
);
  frame_st_e         state_q;
  logic [HC_W-1:0]   hcnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  idx_q;
  logic              hdr_last;

  assign hdr_last = (hcnt_q == HC_W'(ADDR_W));
  assign load_o   = active_i && (state_q == ST_HDR) && rise_i && hdr_last && !din_i;
  assign shift_o  = active_i && (state_q == ST_READ) && fall_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HDR;
      hcnt_q  <= '0;
      addr_q  <= '0;
      idx_q   <= '0;
    end else if (!active_i) begin
      state_q <= ST_HDR;
      hcnt_q  <= '0;
      addr_q  <= '0;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_HDR: if (rise_i) begin
          if (hdr_last) state_q <= din_i ? ST_SKIP : ST_READ;
          else begin
            addr_q <= {addr_q[ADDR_W-2:0], din_i};
            hcnt_q <= hcnt_q + 1'b1;
          end
        end
        ST_READ: if (fall_i && idx_q != CNT_W'(ONES_LEN)) idx_q <= idx_q + 1'b1;
        default: ;
      endcase
    end
  end

  assign state_o = state_q;
  assign addr_o  = addr_q;
  assign idx_o   = idx_q;

  // R3
  idx_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && state_q == ST_READ && $past(state_q == ST_READ)) |-> (idx_q >= $past(idx_q)));

  // R1
  hdr_addr_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_HDR && $past(state_q != ST_HDR) && active_i) |-> $stable(addr_q));
endmodule

// File: rtl/ser_bit_sel.sv
module ser_bit_sel #(
  parameter int                        ADDR_W     = 4,
  parameter int                        DATA_W     = 32,
  parameter int                        ONES_LEN   = 32,
  localparam int                       NREG       = 2 ** ADDR_W,
  localparam int                       WF_W       = $clog2(DATA_W + 1),
  localparam int                       CNT_W      = $clog2(ONES_LEN + 1),
  localparam int                       POS_W      = $clog2(DATA_W),
  parameter logic [NREG-1:0]           VALID_MASK = '1,
  parameter logic [NREG*WF_W-1:0]      REG_W_TAB  = '0
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  idx_i,
  output logic              bit_o
);
  logic [WF_W-1:0]  width;
  logic [POS_W-1:0] pos;

  always_comb begin
    width = REG_W_TAB[addr_i*WF_W +: WF_W];
    pos   = POS_W'(int'(width) - 1 - int'(idx_i));
    if (!VALID_MASK[addr_i])            bit_o = (int'(idx_i) < ONES_LEN);
    else if (int'(idx_i) < int'(width)) bit_o = data_i[pos];
    else                                bit_o = 1'b0;
  end
endmodule

// File: rtl/ser_reg_rd_slave.sv
module ser_reg_rd_slave
  import ser_rd_pkg::*;
#(
  parameter int  ADDR_W     = 4,
  parameter int  DATA_W     = 32,
  parameter int  ONES_LEN   = 32,
  parameter int  SYNC_STG   = 2,
  localparam int NREG       = 2 ** ADDR_W,
  localparam int WF_W       = $clog2(DATA_W + 1),
  localparam int CNT_W      = $clog2(ONES_LEN + 1),
  parameter logic [NREG-1:0]      VALID_MASK = 16'h5B5F,
  parameter logic [NREG*WF_W-1:0] REG_W_TAB  = {6'd1, 6'd2, 6'd1, 6'd31, 6'd3, 6'd1, 6'd12, 6'd5,
                                                6'd1, 6'd24, 6'd1, 6'd16, 6'd8, 6'd1, 6'd32, 6'd10}
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sel_ni,
  input  logic                   sclk_i,
  input  logic                   sdata_i,
  output logic                   sdata_o,
  output logic                   sdata_oe_o,
  input  logic [NREG*DATA_W-1:0] regs_i
);
  logic [2:0]        lvl;
  logic              rise, fall, active;
  frame_st_e         state;
  logic [ADDR_W-1:0] addr;
  logic [CNT_W-1:0]  idx;
  logic              load, shift, nxt_bit;
  logic [DATA_W-1:0] snap_q;

  // bit 0 sclk, bit 1 sdata, bit 2 select
  ser_in_sync #(.N(3), .STAGES(SYNC_STG), .CLK_BIT(0), .RST_VAL(3'b100)) i_sync (
    .clk_i, .rst_ni,
    .async_i    ({sel_ni, sdata_i, sclk_i}),
    .level_o    (lvl),
    .clk_rise_o (rise),
    .clk_fall_o (fall)
  );

  assign active = ~lvl[2];

  ser_frame_ctrl #(.ADDR_W(ADDR_W), .ONES_LEN(ONES_LEN)) i_ctrl (
    .clk_i, .rst_ni,
    .active_i (active),
    .rise_i   (rise),
    .fall_i   (fall),
    .din_i    (lvl[1]),
    .state_o  (state),
    .addr_o   (addr),
    .idx_o    (idx),
    .load_o   (load),
    .shift_o  (shift)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   snap_q <= '0;
    else if (load) snap_q <= regs_i[addr*DATA_W +: DATA_W];
  end

  ser_bit_sel #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ONES_LEN(ONES_LEN),
    .VALID_MASK(VALID_MASK), .REG_W_TAB(REG_W_TAB)
  ) i_bsel (
    .data_i (snap_q),
    .addr_i (addr),
    .idx_i  (idx),
    .bit_o  (nxt_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sdata_o    <= 1'b0;
      sdata_oe_o <= 1'b0;
    end else if (!active) begin
      sdata_o    <= 1'b0;
      sdata_oe_o <= 1'b0;
    end else if (shift) begin
      sdata_o    <= nxt_bit;
      sdata_oe_o <= 1'b1;
    end
  end

  // R6
  desel_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> !sdata_oe_o);

  // R2
  oe_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdata_oe_o) |-> ($past(state) == ST_READ && !lvl[0]));

  // R3
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdata_oe_o && $past(sdata_oe_o) && !$past(shift)) |-> $stable(sdata_o));

  // R7
  skip_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_SKIP && $past(state == ST_SKIP)) |-> !sdata_oe_o);

  // R8
  snap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_READ && $past(state == ST_READ)) |-> $stable(snap_q));
endmodule

// File: tb/test_ser_reg_rd_slave.sv
module test_ser_reg_rd_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int NREG       = 16;
  localparam logic [15:0]   VMASK = 16'h5B5F;
  localparam logic [95:0]   WTAB  = {6'd1, 6'd2, 6'd1, 6'd31, 6'd3, 6'd1, 6'd12, 6'd5,
                                     6'd1, 6'd24, 6'd1, 6'd16, 6'd8, 6'd1, 6'd32, 6'd10};

  logic clk = 0, rst_ni = 0, sel_ni = 1, sclk = 0, sdin = 0;
  logic sdata_o, sdata_oe_o;
  logic [NREG*32-1:0] regs;
  logic [31:0] drv_v [NREG];
  logic [31:0] ref_v [NREG];
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb for (int a = 0; a < NREG; a++) regs[a*32 +: 32] = drv_v[a];

  ser_reg_rd_slave i_ser_reg_rd_slave (
    .clk_i(clk), .rst_ni, .sel_ni, .sclk_i(sclk), .sdata_i(sdin),
    .sdata_o, .sdata_oe_o, .regs_i(regs)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int wid(int a);
    return int'(WTAB[a*6 +: 6]);
  endfunction

  function automatic logic exp_bit(int a, int i);
    if (!VMASK[a]) return (i < 32);
    if (i < wid(a)) return ref_v[a][wid(a)-1-i];
    return 1'b0;
  endfunction

  task automatic hwait();
    repeat (HALF) @(negedge clk);
  endtask

  // change_at >= 0: parallel input is altered at that data bit (R8)
  task automatic frame(int a, bit rw, int nbits, int change_at);
    string tag;
    sel_ni = 0;
    hwait();
    for (int h = 0; h < 5; h++) begin
      sdin = (h < 4) ? a[3-h] : rw;
      hwait();
      chk("R2 hdr oe", {31'd0, sdata_oe_o}, 0);
      sclk = 1;
      hwait();
      if (h == 4) chk("R2 pre-turn oe", {31'd0, sdata_oe_o}, 0);
      sclk = 0;
    end
    for (int i = 0; i < nbits; i++) begin
      hwait();
      if (rw) chk("R7 oe", {31'd0, sdata_oe_o}, 0);
      else begin
        chk("R2 oe", {31'd0, sdata_oe_o}, 1);
        if (!VMASK[a])       tag = (i < 32) ? "R5 ones" : "R5 zeros";
        else if (i >= wid(a)) tag = "R4";
        else                  tag = (wid(a) == 1 || wid(a) == 32) ? "R10" : "R3";
        chk($sformatf("%s a=%0d bit=%0d", tag, a, i), {31'd0, sdata_o}, {31'd0, exp_bit(a, i)});
      end
      if (i == change_at) drv_v[a] = ~drv_v[a];
      sclk = 1;
      hwait();
      sclk = 0;
    end
    hwait();
    sel_ni = 1;
    repeat (6) @(negedge clk);
    chk("R6 oe drop", {31'd0, sdata_oe_o}, 0);
    chk("R6 data clr", {31'd0, sdata_o}, 0);
    hwait();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < NREG; a++) begin
      drv_v[a] = 32'hA5C3_0F69 ^ (a * 32'h1357_9BDF);
      ref_v[a] = drv_v[a];
    end
    repeat (3) @(negedge clk);
    // R9
    chk("R9 oe rst", {31'd0, sdata_oe_o}, 0);
    chk("R9 data rst", {31'd0, sdata_o}, 0);
    rst_ni = 1;
    repeat (3) @(negedge clk);
    chk("R9 oe post", {31'd0, sdata_oe_o}, 0);

    // R1 R3 R4 R5 R10: all addresses, two patterns
    for (int p = 0; p < 2; p++) begin
      for (int a = 0; a < NREG; a++) begin
        if (p == 1) begin drv_v[a] = ~drv_v[a]; ref_v[a] = drv_v[a]; end
        frame(a, 1'b0, VMASK[a] ? wid(a) + 3 : 36, -1);
      end
    end

    // R6: two-bit read then full fresh read
    frame(0, 1'b0, 2, -1);
    frame(0, 1'b0, wid(0), -1);
    frame(1, 1'b0, 1, -1);
    frame(9, 1'b0, wid(9) + 1, -1);

    // R7: direction 1 never drives
    frame(1, 1'b1, 20, -1);
    frame(0, 1'b0, wid(0), -1);

    // R8: input flips at bit 3, expect old value
    frame(1, 1'b0, 32, 3);
    ref_v[1] = drv_v[1];
    frame(1, 1'b0, 32, -1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule